// File: doc/BRIEF.md
# Register Modification Tracker

The tracker keeps a record of the general-register changes made by auto-increment and auto-decrement addressing while one instruction executes. If a memory access of that instruction aborts, software can read the record and undo the changes before it restarts the instruction. The address calculation sends one strobe for each register change. The strobe carries a 3-bit register number and three qualifiers: the direction, the operand size and whether the mode is indirect. From these the block works out the signed change amount.

The record is a 16-bit word made of two byte slots, which are filled in order. An instruction-start pulse empties the record. A freeze input is held high while an abort is pending. While it is high, the record holds the state of the faulting instruction: it ignores both new strobes and the start pulse.

Top module: `rmt_top`

## Requirements
- R1: After reset, rdData is 16'h0000.
- R2: Each slot is 8 bits wide. Bits [2:0] hold the register number and bits [7:3] hold the change amount as 5-bit two's complement. The low slot is rdData[7:0] and the high slot is rdData[15:8].
- R3: Within one instruction, the first accepted change goes into the low slot and the second into the high slot, in the order the strobes arrive.
- R4: The amount is +1 for a byte-sized direct increment and +2 for a word-sized one. An indirect mode gives +2 whatever the operand size. With chgDec=1 the amount is negated, giving -1 (5'b11111) or -2 (5'b11110).
- R5: An instruction with no change strobe leaves rdData at zero. An instruction with exactly one change leaves the high slot at zero.
- R6: When freeze is low, instStart clears both slots on the next clock edge. A strobe in the same cycle is recorded as the first change of the new instruction.
- R7: While freeze is high, rdData holds its value. Change strobes and instStart have no effect.
- R8: A third or later change strobe within one instruction is ignored.
- R9: A change accepted in the cycle before freeze rises stays in rdData while freeze is high. This holds even though the access that used the changed address aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instStart | input | 1 | Pulse at the start of each instruction |
| freeze | input | 1 | Holds the record while an abort is pending |
| chgValid | input | 1 | A register change occurs this cycle |
| chgReg | input | 3 | Number of the changed register |
| chgDec | input | 1 | 1 = decrement, 0 = increment |
| chgByte | input | 1 | 1 = byte operand, 0 = word operand |
| chgInd | input | 1 | 1 = indirect auto mode |
| rdData | output | 16 | Record contents |

## Verification
The assertions assume that instStart and chgValid are registered levels that are only meaningful at a clock edge. They also assume that freeze stays high for at least one edge once it rises. Some checks take the low slot being zero to mean that a fresh instruction has begun. This is safe because every recorded amount is nonzero. The stimulus changes every input only at the falling edge. It sweeps all registers and qualifier combinations one at a time and in pairs, and it raises freeze only between whole strobe cycles.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  parameter int REG_NUM_W = 3;
  parameter int AMT_W     = 5;
  parameter int NUM_SLOTS = 2;
  localparam int SLOT_W   = REG_NUM_W + AMT_W;
  localparam int REC_W    = SLOT_W * NUM_SLOTS;
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1);

  typedef struct packed {
    logic                 clrAll;
    logic [NUM_SLOTS-1:0] wrSlot;
  } rmtStrobeT;
endpackage

// File: rtl/rmt_ctrl.sv
module rmt_ctrl
  import rmt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      instStart,
  input  logic      freeze,
  input  logic      chgValid,
  output rmtStrobeT stb
);
  logic [CNT_W-1:0] fillCnt;
  logic clrNow, acceptNow;

  assign clrNow    = instStart & ~freeze;
  assign acceptNow = chgValid & ~freeze;

  assign stb.clrAll = clrNow;

  // a slot is written when the fill count points at it (a clear restarts at slot 0)
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_wr
    assign stb.wrSlot[i] = acceptNow &
                           (clrNow ? (i == 0) : (fillCnt == CNT_W'(i)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (clrNow) begin
      fillCnt <= acceptNow ? CNT_W'(1) : '0;
    end else if (acceptNow && (fillCnt < CNT_W'(NUM_SLOTS))) begin
      fillCnt <= fillCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rmt_datapath.sv
module rmt_datapath
  import rmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  rmtStrobeT            stb,
  input  logic [REG_NUM_W-1:0] chgReg,
  input  logic                 chgDec,
  input  logic                 chgByte,
  input  logic                 chgInd,
  output logic [REC_W-1:0]     record
);
  logic [AMT_W-1:0]  magnitude;
  logic [AMT_W-1:0]  amount;
  logic [SLOT_W-1:0] entry;

  // indirect modes step over a pointer word, so they always move by two
  assign magnitude = (chgInd || !chgByte) ? AMT_W'(2) : AMT_W'(1);
  assign amount    = chgDec ? (~magnitude + AMT_W'(1)) : magnitude;
  assign entry     = {amount, chgReg};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [SLOT_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (stb.clrAll) begin
        slotQ <= stb.wrSlot[i] ? entry : '0;
      end else if (stb.wrSlot[i]) begin
        slotQ <= entry;
      end
    end
    assign record[i*SLOT_W +: SLOT_W] = slotQ;
  end
endmodule

// File: rtl/rmt_top.sv
module rmt_top
  import rmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instStart,
  input  logic        freeze,
  input  logic        chgValid,
  input  logic [2:0]  chgReg,
  input  logic        chgDec,
  input  logic        chgByte,
  input  logic        chgInd,
  output logic [15:0] rdData
);
  rmtStrobeT stb;

  rmt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .instStart(instStart), .freeze(freeze),
    .chgValid(chgValid), .stb(stb)
  );

  rmt_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .chgReg(chgReg), .chgDec(chgDec),
    .chgByte(chgByte), .chgInd(chgInd), .record(rdData)
  );
endmodule

// File: rtl/rmt_checker.sv
module rmt_checker (
  input logic        clk,
  input logic        rstN,
  input logic        instStart,
  input logic        freeze,
  input logic        chgValid,
  input logic [15:0] rdData
);
  // R6: a clear with no strobe empties the record
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (instStart && !freeze && !chgValid) |=> (rdData == 16'h0000));

  // R7: frozen record never moves
  a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> $stable(rdData));

  // R3/R5: the high slot is only filled after the low slot
  a_r3_low_first: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15:8] != 8'h00) |-> (rdData[7:0] != 8'h00));

  // R4: a first change lands with an amount of +-1 or +-2
  a_r4_amount_range: assert property (@(posedge clk) disable iff (!rstN)
    (chgValid && !freeze && !instStart && rdData == 16'h0000) |=>
      (rdData[7:3] == 5'd1 || rdData[7:3] == 5'd2 ||
       rdData[7:3] == 5'b11111 || rdData[7:3] == 5'b11110));

  // R8: both slots full and no clear -> nothing changes
  a_r8_third_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15:8] != 8'h00 && !instStart) |=> $stable(rdData));
endmodule

bind rmt_top rmt_checker i_chk (
  .clk(clk), .rstN(rstN), .instStart(instStart), .freeze(freeze),
  .chgValid(chgValid), .rdData(rdData)
);

// File: tb/test_rmt_top.sv
module test_rmt_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic instStart = 0, freeze = 0, chgValid = 0, chgDec = 0, chgByte = 0, chgInd = 0;
  logic [2:0] chgReg = 0;
  logic [15:0] rdData;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rmt_top i_rmt_top (
    .clk(clk), .rstN(rstN), .instStart(instStart), .freeze(freeze),
    .chgValid(chgValid), .chgReg(chgReg), .chgDec(chgDec), .chgByte(chgByte),
    .chgInd(chgInd), .rdData(rdData)
  );

  function automatic logic [7:0] ent(int rg, bit dec, bit byt, bit ind);
    int mag = (ind || !byt) ? 2 : 1;
    logic [4:0] a = dec ? 5'(32 - mag) : 5'(mag);
    return {a, 3'(rg)};
  endfunction

  task automatic check(string req, logic [15:0] exp);
    nChecks++;
    if (rdData !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, rdData, exp);
    end
  endtask

  // drive one cycle at the falling edge; the rising edge in between registers it
  task automatic step(bit st, bit fr, bit v, int rg, bit dec, bit byt, bit ind);
    instStart = st; freeze = fr; chgValid = v; chgReg = 3'(rg);
    chgDec = dec; chgByte = byt; chgInd = ind;
    @(negedge clk);
    instStart = 0; chgValid = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1", 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000);

    // R2 R4 R5: every single change
    for (int rg = 0; rg < 8; rg++)
      for (int q = 0; q < 8; q++) begin
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 1, rg, q[0], q[1], q[2]);
        step(0, 0, 0, 0, 0, 0, 0);
        check("R4", {8'h00, ent(rg, q[0], q[1], q[2])});
      end

    // R5: instruction with no change
    step(1, 0, 0, 0, 0, 0, 0);
    check("R5", 16'h0000);

    // R3 R2: pairs in order
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 1, a, a[0], b[1], 0);
        step(0, 0, 1, 7 - b, b[0], 0, a[2]);
        check("R3", {ent(7 - b, b[0], 0, a[2]), ent(a, a[0], b[1], 0)});
      end

    // R8: third change ignored
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0, 1, 0);
    step(0, 0, 1, 2, 1, 0, 0);
    step(0, 0, 1, 3, 0, 0, 1);
    check("R8", {ent(2, 1, 0, 0), ent(1, 0, 1, 0)});

    // R6: start with a same-cycle strobe
    step(1, 0, 1, 5, 1, 1, 0);
    check("R6", {8'h00, ent(5, 1, 1, 0)});

    // R9 R7: change then freeze; strobes and start ignored while frozen
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 4, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    check("R9", {8'h00, ent(4, 0, 0, 0)});
    step(0, 1, 1, 6, 1, 0, 1);
    check("R7", {8'h00, ent(4, 0, 0, 0)});
    step(1, 1, 0, 0, 0, 0, 0);
    check("R7", {8'h00, ent(4, 0, 0, 0)});
    step(1, 1, 1, 3, 1, 1, 0);
    check("R7", {8'h00, ent(4, 0, 0, 0)});
    freeze = 0;
    step(1, 0, 0, 0, 0, 0, 0);
    check("R6", 16'h0000);

    finished = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule